// File: doc/BRIEF.md
# Hashed Perceptron Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A request carries the branch address and its target. The block adds a per-address bias weight to one signed weight for each recent branch outcome. Each history weight counts positively when that recorded outcome was taken and negatively when it was not. A non-negative total means "taken". The result, and the total that produced it, appear one cycle after the request.

The history is a circular buffer of recent branches. Each entry holds the predicted direction and a few hashed bits of the target. The history positions are grouped into blocks of consecutive positions. Each block selects its weight row with a hash: the shifted branch address is XORed with the shifted targets of that block's history entries. This makes the choice of weights depend on the path taken to reach the branch, not only on outcomes.

When the branch resolves, the core reports the real direction and the direction it had been given. The block trains if the guess was wrong, or if the stored total was too close to zero. Training works on a snapshot taken at prediction time: the total, the bias index, the row indices and the history directions. Only one prediction can await resolution at a time.

Top module: `hashed_perceptron_bp`

## Requirements
- R1: After reset every weight is zero, every path entry is zero (not-taken, target bits zero), the path pointer is zero and `predDone` is low. The first prediction therefore returns total 0 and taken.
- R2: The bias weight is selected by `(predAddr >> ADDR_SHIFT) mod BIAS_N` and is added to the total.
- R3: History position k (k = 0 is the most recent branch) reads path entry `(ptr - 1 - k) mod HIST_LEN`. Position k lies in block `k / BLOCK` and column `k mod BLOCK`. The row for block b is `((predAddr >> ADDR_SHIFT) XOR the (target >> ADDR_SHIFT) of the BLOCK entries of that block) mod ROWS`.
- R4: Each history weight is added when its entry's direction bit is 1 (taken) and subtracted when it is 0. `predDone` is high in exactly the cycle after `predValid` was high, with `predSum` holding the total.
- R5: `predTaken` is 1 exactly when the signed total is greater than or equal to zero.
- R6: A prediction writes its own predicted direction and target into the path entry at the pointer. The pointer then advances modulo HIST_LEN.
- R7: A resolution trains only when `updPredTaken != updActual` or when the absolute value of the snapshot total is at most THETA.
- R8: Training moves each history weight by +1 when the snapshot direction of its position equals `updActual`, and by -1 otherwise. It moves the bias weight by +1 on taken and -1 on not-taken. Every weight saturates at 2^WEIGHT_BITS-1 and -2^WEIGHT_BITS.
- R9: Training uses the snapshot from prediction time. When a prediction and a resolution arrive in the same cycle, the resolution trains the earlier snapshot, and the new prediction sees the weights as they were before that training.
- R10: A resolution with no prediction pending is ignored. Any resolution ends the pending state unless a new prediction arrives in the same cycle, so at most one training follows each prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| predValid | input | 1 | Prediction request |
| predAddr | input | ADDR_W | Branch address |
| predTarget | input | ADDR_W | Branch target recorded in the path history |
| predDone | output | 1 | Result valid, one cycle after request |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| predSum | output | WEIGHT_BITS+clog2(HIST_LEN+1)+2 | Signed total behind the prediction |
| updValid | input | 1 | Resolution of the pending prediction |
| updActual | input | 1 | Resolved direction, 1 = taken |
| updPredTaken | input | 1 | Direction the core was given for this branch |

## Verification
A corrupted weight, a wrong row hash or a misplaced path entry shows at the ports as a wrong `predSum` on the next prediction that selects the damaged row or position. That prediction can come as early as the cycle after the fault. The bench therefore compares `predSum` and `predTaken` against a behavioural model on every prediction. A training step that used live state instead of the snapshot, or that fired on an ignored resolution, changes weights the model leaves alone. Those errors surface as total mismatches a few predictions later, at the latest once the same branch is predicted again. Saturation limits and the threshold rule are pinned by directed runs whose final totals are known in closed form.

// File: rtl/perceptron_pkg.sv
package perceptron_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // compute prediction, snapshot, write path, advance pointer
    logic train;    // apply saturating update using the snapshot
  } strobe_t;
endpackage

// File: rtl/perceptron_ctrl.sv
module perceptron_ctrl
  import perceptron_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    predValid,
  input  logic    updValid,
  input  logic    updPredTaken,
  input  logic    updActual,
  input  logic    lowConf,
  output strobe_t stb
);
  logic pending;

  always_comb begin
    stb.capture = predValid;
    // R7, R10: train only a pending snapshot, on mispredict or low confidence
    stb.train   = updValid && pending && ((updPredTaken != updActual) || lowConf);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (predValid) begin
      pending <= 1'b1;
    end else if (updValid) begin
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/perceptron_dp.sv
module perceptron_dp
  import perceptron_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BIAS_N      = 1024,
  parameter int ROWS        = 256,
  parameter int HIST_LEN    = 64,
  parameter int BLOCK       = 8,
  parameter int WEIGHT_BITS = 7,
  parameter int THETA       = 137,
  parameter int ADDR_SHIFT  = 4,
  parameter int SUM_W       = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [ADDR_W-1:0]       predAddr,
  input  logic [ADDR_W-1:0]       predTarget,
  input  logic                    updActual,
  output logic                    predDone,
  output logic                    predTaken,
  output logic signed [SUM_W-1:0] predSum,
  output logic                    lowConf
);
  localparam int WB     = WEIGHT_BITS + 1;
  localparam int NB     = HIST_LEN / BLOCK;
  localparam int PTR_W  = $clog2(HIST_LEN);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int BIAS_W = $clog2(BIAS_N);
  localparam int WMAX   = 2 ** WEIGHT_BITS - 1;
  localparam int WMIN   = -(2 ** WEIGHT_BITS);
  localparam logic signed [SUM_W-1:0] THETA_S = SUM_W'(THETA);

  typedef logic signed [WB-1:0] wgt_t;

  function automatic logic signed [SUM_W-1:0] sext(input wgt_t w);
    return SUM_W'(w);
  endfunction

  function automatic wgt_t satStep(input wgt_t w, input logic up);
    if (up) return (w == wgt_t'(WMAX)) ? w : w + wgt_t'(1);
    else    return (w == wgt_t'(WMIN)) ? w : w - wgt_t'(1);
  endfunction

  // Weight storage: one table per history block, a row holds BLOCK weights
  wgt_t                  biasTab [BIAS_N];
  logic [BLOCK*WB-1:0]   rowTab  [NB][ROWS];

  // Path history: direction bit and hashed target bits only
  logic [HIST_LEN-1:0]   pathTaken;
  logic [ROW_W-1:0]      pathTgt [HIST_LEN];
  logic [PTR_W-1:0]      ptr;

  // Snapshot for training
  logic signed [SUM_W-1:0] snapSum;
  logic [BIAS_W-1:0]       snapBias;
  logic [ROW_W-1:0]        snapRow [NB];
  logic [HIST_LEN-1:0]     snapHist;

  // Lookup
  logic [BIAS_W-1:0]       biasIdx;
  logic [ROW_W-1:0]        addrKey;
  logic [ROW_W-1:0]        rowIdx [NB];
  logic [HIST_LEN-1:0]     histNow;
  logic signed [SUM_W-1:0] sumNow;

  assign biasIdx = BIAS_W'(predAddr >> ADDR_SHIFT);
  assign addrKey = ROW_W'(predAddr >> ADDR_SHIFT);

  // R3: position k reads entry ptr-1-k; rows hashed per block
  always_comb begin
    for (int b = 0; b < NB; b++) begin
      logic [ROW_W-1:0] h;
      h = addrKey;
      for (int j = 0; j < BLOCK; j++) begin
        h = h ^ pathTgt[ptr - PTR_W'(b*BLOCK + j + 1)];
      end
      rowIdx[b] = h;
    end
    for (int k = 0; k < HIST_LEN; k++) begin
      histNow[k] = pathTaken[ptr - PTR_W'(k + 1)];
    end
  end

  // R2, R4: signed dot product
  always_comb begin
    sumNow = sext(biasTab[biasIdx]);
    for (int b = 0; b < NB; b++) begin
      for (int j = 0; j < BLOCK; j++) begin
        wgt_t w;
        w = rowTab[b][rowIdx[b]][j*WB +: WB];
        if (histNow[b*BLOCK + j]) sumNow = sumNow + sext(w);
        else                      sumNow = sumNow - sext(w);
      end
    end
  end

  assign lowConf = (snapSum <= THETA_S) && (snapSum >= -THETA_S);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      predDone  <= 1'b0;
      predTaken <= 1'b0;
      predSum   <= '0;
      ptr       <= '0;
      pathTaken <= '0;
      snapSum   <= '0;
      snapBias  <= '0;
      snapHist  <= '0;
      for (int k = 0; k < HIST_LEN; k++) pathTgt[k] <= '0;
      for (int b = 0; b < NB; b++) begin
        snapRow[b] <= '0;
        for (int r = 0; r < ROWS; r++) rowTab[b][r] <= '0;
      end
      for (int i = 0; i < BIAS_N; i++) biasTab[i] <= '0;
    end else begin
      predDone <= stb.capture;
      if (stb.capture) begin
        predTaken      <= !sumNow[SUM_W-1];      // R5
        predSum        <= sumNow;
        snapSum        <= sumNow;
        snapBias       <= biasIdx;
        snapHist       <= histNow;
        for (int b = 0; b < NB; b++) snapRow[b] <= rowIdx[b];
        pathTaken[ptr] <= !sumNow[SUM_W-1];      // R6
        pathTgt[ptr]   <= ROW_W'(predTarget >> ADDR_SHIFT);
        ptr            <= ptr + PTR_W'(1);
      end
      if (stb.train) begin                       // R8, R9: snapshot only
        biasTab[snapBias] <= satStep(biasTab[snapBias], updActual);
        for (int b = 0; b < NB; b++) begin
          for (int j = 0; j < BLOCK; j++) begin
            rowTab[b][snapRow[b]][j*WB +: WB] <=
              satStep(rowTab[b][snapRow[b]][j*WB +: WB], snapHist[b*BLOCK + j] == updActual);
          end
        end
      end
    end
  end
endmodule

// File: rtl/hashed_perceptron_bp.sv
module hashed_perceptron_bp
  import perceptron_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BIAS_N      = 1024,
  parameter int ROWS        = 256,
  parameter int HIST_LEN    = 64,
  parameter int BLOCK       = 8,
  parameter int WEIGHT_BITS = 7,
  parameter int THETA       = 137,
  parameter int ADDR_SHIFT  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    predValid,
  input  logic [ADDR_W-1:0]       predAddr,
  input  logic [ADDR_W-1:0]       predTarget,
  output logic                    predDone,
  output logic                    predTaken,
  output logic signed [WEIGHT_BITS+$clog2(HIST_LEN+1)+1:0] predSum,
  input  logic                    updValid,
  input  logic                    updActual,
  input  logic                    updPredTaken
);
  localparam int SUM_W = WEIGHT_BITS + $clog2(HIST_LEN + 1) + 2;

  strobe_t stb;
  logic    lowConf;

  perceptron_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .predValid    (predValid),
    .updValid     (updValid),
    .updPredTaken (updPredTaken),
    .updActual    (updActual),
    .lowConf      (lowConf),
    .stb          (stb)
  );

  perceptron_dp #(
    .ADDR_W      (ADDR_W),
    .BIAS_N      (BIAS_N),
    .ROWS        (ROWS),
    .HIST_LEN    (HIST_LEN),
    .BLOCK       (BLOCK),
    .WEIGHT_BITS (WEIGHT_BITS),
    .THETA       (THETA),
    .ADDR_SHIFT  (ADDR_SHIFT),
    .SUM_W       (SUM_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .predAddr   (predAddr),
    .predTarget (predTarget),
    .updActual  (updActual),
    .predDone   (predDone),
    .predTaken  (predTaken),
    .predSum    (predSum),
    .lowConf    (lowConf)
  );
endmodule

// File: rtl/hashed_perceptron_chk.sv
module hashed_perceptron_chk
  import perceptron_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    predValid,
  input logic    predDone,
  input logic    predTaken,
  input logic    sumNeg,
  input logic    updValid,
  input strobe_t stb
);
  p_done_after_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    predValid |=> predDone);

  p_quiet_without_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    !predValid |=> !predDone);

  p_taken_is_sign_r5: assert property (@(posedge clk) disable iff (!rstN)
    predDone |-> (predTaken != sumNeg));

  p_train_needs_update_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.train |-> updValid);

  p_single_train_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.train && !predValid) |=> !stb.train);
endmodule

bind hashed_perceptron_bp hashed_perceptron_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .predValid (predValid),
  .predDone  (predDone),
  .predTaken (predTaken),
  .sumNeg    (predSum[SUM_W-1]),
  .updValid  (updValid),
  .stb       (stb)
);

// File: tb/tb_hashed_perceptron_bp.sv
`timescale 1ns/1ps
module tb_hashed_perceptron_bp;
  localparam int AW = 32, BN = 16, RN = 4, HL = 8, BL = 4, WBITS = 7, TH = 30, SH = 4;
  localparam int NB = HL / BL;
  localparam int SW = WBITS + $clog2(HL + 1) + 2;
  localparam int WHI = 2 ** WBITS - 1, WLO = -(2 ** WBITS);

  logic clk = 0, rstN = 0;
  logic predValid = 0, updValid = 0, updActual = 0, updPredTaken = 0;
  logic [AW-1:0] predAddr = '0, predTarget = '0;
  logic predDone, predTaken;
  logic signed [SW-1:0] predSum;

  hashed_perceptron_bp #(.ADDR_W(AW), .BIAS_N(BN), .ROWS(RN), .HIST_LEN(HL), .BLOCK(BL),
    .WEIGHT_BITS(WBITS), .THETA(TH), .ADDR_SHIFT(SH)) dut (.*);

  always #4 clk = ~clk;

  int nChecks = 0, nFail = 0;
  bit finished = 0;
  int gotSum; bit gotTaken;

  // behavioural reference state
  int mBias[BN];
  int mW[NB][RN][BL];
  bit mPathT[HL];
  int unsigned mPathTgt[HL];
  int mPtr = 0; bit mPend = 0;
  int mSnapSum, mSnapBias;
  int mSnapRow[NB];
  bit mSnapHist[HL];

  function automatic int clampW(int v);
    return (v > WHI) ? WHI : (v < WLO) ? WLO : v;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit pv, logic [AW-1:0] a, logic [AW-1:0] t,
                      bit uv, bit act, bit up, string tag);
    int s; int bIdx; int idx[NB]; bit hs[HL];
    s = 0; bIdx = 0;
    if (pv) begin
      bIdx = int'((a >> SH) % BN);
      s = mBias[bIdx];
      for (int b = 0; b < NB; b++) begin
        int unsigned h;
        h = a >> SH;
        for (int j = 0; j < BL; j++) h ^= mPathTgt[(mPtr - 1 - (b*BL + j) + 2*HL) % HL] >> SH;
        idx[b] = int'(h % RN);
        for (int j = 0; j < BL; j++) begin
          int k; int sl;
          k = b*BL + j; sl = (mPtr - 1 - k + 2*HL) % HL;
          hs[k] = mPathT[sl];
          s += mPathT[sl] ? mW[b][idx[b]][j] : -mW[b][idx[b]][j];
        end
      end
    end
    if (uv && mPend) begin
      if (up != act || (mSnapSum <= TH && mSnapSum >= -TH)) begin
        mBias[mSnapBias] = clampW(mBias[mSnapBias] + (act ? 1 : -1));
        for (int b = 0; b < NB; b++)
          for (int j = 0; j < BL; j++)
            mW[b][mSnapRow[b]][j] = clampW(mW[b][mSnapRow[b]][j] + ((mSnapHist[b*BL+j] == act) ? 1 : -1));
      end
      mPend = 0;
    end
    if (pv) begin
      mSnapSum = s; mSnapBias = bIdx;
      for (int b = 0; b < NB; b++) mSnapRow[b] = idx[b];
      for (int k = 0; k < HL; k++) mSnapHist[k] = hs[k];
      mPathT[mPtr] = (s >= 0); mPathTgt[mPtr] = t;
      mPtr = (mPtr + 1) % HL; mPend = 1;
    end
    predValid = pv; predAddr = a; predTarget = t;
    updValid = uv; updActual = act; updPredTaken = up;
    @(negedge clk);
    predValid = 0; updValid = 0;
    check(predDone == pv, "R4", "predDone", int'(predDone), int'(pv));
    if (pv) begin
      gotSum = int'(predSum); gotTaken = predTaken;
      check(gotSum == s, tag, "predSum", gotSum, s);
      check(gotTaken == (s >= 0), "R5", "predTaken", int'(gotTaken), int'(s >= 0));
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    end
  endtask

  initial begin
    #(8 * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog R4 actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    check(predDone == 0, "R1", "predDone in reset", int'(predDone), 0);
    rstN = 1;
    @(negedge clk);
    check(predDone == 0, "R1", "predDone after reset", int'(predDone), 0);

    // R1: first prediction sees all-zero state
    step(1, 32'h1230, 32'h4000, 0, 0, 0, "R1");
    check(gotSum == 0, "R1", "first sum", gotSum, 0);
    check(gotTaken == 1, "R1", "first taken", int'(gotTaken), 1);
    step(0, 0, 0, 1, 1, 1, "R7");

    // R7: correct predictions train until confidence exceeds THETA
    for (int i = 0; i < 30; i++) begin
      step(1, 32'h1230, 32'h4000, 0, 0, 0, "R7");
      step(0, 0, 0, 1, 1, 1, "R7");
    end
    s0 = gotSum;
    check(s0 > TH, "R7", "confident sum above theta", s0, TH + 1);
    for (int i = 0; i < 4; i++) begin
      step(1, 32'h1230, 32'h4000, 0, 0, 0, "R7");
      step(0, 0, 0, 1, 1, 1, "R7");
      check(gotSum == s0, "R7", "no training when confident", gotSum, s0);
    end

    // R8: forced training saturates at the upper limit
    for (int i = 0; i < 300; i++) begin
      step(1, 32'h1230, 32'h4000, 0, 0, 0, "R8");
      step(0, 0, 0, 1, 1, 0, "R8");
    end
    step(1, 32'h1230, 32'h4000, 0, 0, 0, "R8");
    check(gotSum == (HL + 1) * WHI, "R8", "upper saturation sum", gotSum, (HL + 1) * WHI);
    step(0, 0, 0, 1, 1, 0, "R8");
    // R8: opposite direction saturates at the lower limit
    for (int i = 0; i < 500; i++) begin
      step(1, 32'h1230, 32'h4000, 0, 0, 0, "R8");
      step(0, 0, 0, 1, 0, 1, "R8");
    end
    step(1, 32'h1230, 32'h4000, 0, 0, 0, "R8");
    check(gotSum == WLO - HL * WHI, "R8", "lower saturation sum", gotSum, WLO - HL * WHI);
    check(gotTaken == 0, "R5", "negative sum not taken", int'(gotTaken), 0);
    step(0, 0, 0, 1, 0, 1, "R8");

    // R10: resolution with nothing pending is ignored
    step(1, 32'h2350, 32'h4010, 0, 0, 0, "R10");
    step(0, 0, 0, 1, 1, 0, "R10");
    step(0, 0, 0, 1, 1, 0, "R10");
    step(0, 0, 0, 1, 0, 1, "R10");
    step(1, 32'h2350, 32'h4010, 0, 0, 0, "R10");
    step(0, 0, 0, 1, 1, 0, "R10");

    // R9: prediction and resolution in the same cycle
    step(1, 32'h3470, 32'h4020, 0, 0, 0, "R9");
    step(1, 32'h3480, 32'h4030, 1, 0, 1, "R9");
    step(1, 32'h3470, 32'h4020, 1, 1, 0, "R9");
    step(0, 0, 0, 1, 1, 0, "R9");
    step(1, 32'h3480, 32'h4030, 0, 0, 0, "R9");

    // R2 R3 R6 R9: mixed random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a, t;
      bit pv, uv, act, up;
      a   = $urandom;
      t   = AW'($urandom_range(0, 15)) << 4;
      pv  = ($urandom_range(0, 3) != 0);
      uv  = ($urandom_range(0, 1) == 1);
      act = a[5] ^ ($urandom_range(0, 4) == 0);
      up  = ($urandom_range(0, 1) == 1);
      step(pv, a, t, uv, act, up, "R2 R3 R6 R9");
    end

    summary();
    $finish;
  end
endmodule